// File: doc/BRIEF.md
# Accumulator Load Executor

This block is a small sequential core that fetches and runs the instructions that load an 8-bit accumulator. It draws instruction bytes from a code memory with a one-cycle read latency (16-bit address, 8-bit data). It reads operands either from that code memory or from a 256-byte internal data memory, which also has a one-cycle read latency. It keeps a program counter, a 16-bit data pointer and an 8-bit status byte. Two bits of the status byte pick one of four banks of eight working registers in the internal data memory.

Six operand forms are decoded:
- a constant that follows the opcode;
- a byte address that follows the opcode;
- a working register of the current bank;
- an internal location pointed to by working register 0 or 1;
- a code byte indexed from the data pointer plus the accumulator;
- a code byte indexed from the program counter plus the accumulator.

Any other opcode is a one-byte instruction with no effect. Each instruction ends with a one-clock `done` pulse. With that pulse, `mcycles` reports the instruction's machine-cycle cost: 2 for the table reads, 1 for everything else.

The core waits in its fetch state until `run` is high. While it waits with `run` low, a pulse on `cfg_we` loads the program counter, the data pointer and the status byte together. A surrounding controller uses this to set up a bank, a pointer or a jump target between instructions.

Top module: `acc_load_core`

## Requirements
- R1: After reset, acc, pc and status are 0 (bank 0), done is low, and no memory read is issued while run is low.
- R2: Opcode 74h loads acc with the byte at pc+1 and advances pc by 2 modulo 65536; done rises on the third clock edge after run is sampled.
- R3: Opcode E5h reads internal data memory at the address held in the byte at pc+1, loads it into acc and advances pc by 2; done rises on the fourth edge.
- R4: Opcode E5h with address byte E0h returns the current acc without a data read, and done rises on the third edge.
- R5: Opcodes E8h–EFh load acc from internal address bank*8 + (opcode bits 2:0) and advance pc by 1; done rises on the third edge.
- R6: The bank number is status bits 4:3; all other status bits have no effect on operand addresses.
- R7: Opcodes E6h and E7h read register 0 or 1 (opcode bit 0) of the current bank as an 8-bit pointer, then load acc from internal memory at that pointer (E0h included, which reads memory). They advance pc by 1, and done rises on the fourth edge.
- R8: Opcode 93h loads acc from code memory at (data pointer + acc) modulo 65536 and advances pc by 1; done rises on the third edge, with mcycles = 2.
- R9: Opcode 83h loads acc from code memory at (opcode address + 1 + acc) modulo 65536 and advances pc by 1, with mcycles = 2.
- R10: Every other opcode leaves acc unchanged and advances pc by 1; done rises on the second edge.
- R11: done is high for exactly one clock per instruction. acc and pc change only on that clock. mcycles is 1 for every non-table instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start the next instruction when the core waits in fetch |
| cfg_we | input | 1 | Load pc, data pointer and status while waiting with run low |
| cfg_pc | input | 16 | Program counter value to load |
| cfg_dptr | input | 16 | Data pointer value to load |
| cfg_status | input | 8 | Status byte to load (bits 4:3 = bank) |
| code_rd | output | 1 | Code memory read strobe |
| code_addr | output | 16 | Code memory address |
| code_data | input | 8 | Code memory data, valid one clock after the strobe |
| data_rd | output | 1 | Internal data memory read strobe |
| data_addr | output | 8 | Internal data memory address |
| data_rdata | input | 8 | Internal data memory data, valid one clock after the strobe |
| acc | output | 8 | Accumulator |
| pc | output | 16 | Program counter |
| status | output | 8 | Status byte |
| done | output | 1 | One-clock pulse at the end of each instruction |
| mcycles | output | 2 | Machine-cycle cost of the instruction ending with done |

## Verification
The bench builds the core with its default widths: a 16-bit code space, an 8-bit internal space, four banks of eight registers, and the accumulator alias at E0h. With these widths the following sweeps are affordable:
- every one of the 256 direct addresses;
- every register of every bank;
- every opcode outside the decoded set.

Chosen pointer and table pairs, together with a program counter loaded next to FFFFh, exercise the modulo-65536 wrap of both the operand fetch and the indexed reads.

// File: rtl/acc_load_pkg.sv
package acc_load_pkg;

  typedef enum logic [2:0] {
    K_NOP,
    K_IMM,
    K_DIR,
    K_REG,
    K_IND,
    K_TDP,
    K_TPC
  } op_kind_t;

  typedef enum logic [2:0] {
    S_FETCH,
    S_DEC,
    S_OPND,
    S_PTR,
    S_DATA,
    S_CODE
  } core_state_t;

endpackage

// File: rtl/acc_load_decode.sv
module acc_load_decode
  import acc_load_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opcode,
  output op_kind_t      kind
);

  always_comb begin
    casez (opcode)
      8'h74:       kind = K_IMM;
      8'hE5:       kind = K_DIR;
      8'b1110_1???: kind = K_REG;
      8'hE6,
      8'hE7:       kind = K_IND;
      8'h93:       kind = K_TDP;
      8'h83:       kind = K_TPC;
      default:     kind = K_NOP;
    endcase
  end

endmodule

// File: rtl/acc_load_agen.sv
module acc_load_agen #(
  parameter int CODE_AW   = 16,
  parameter int DATA_AW   = 8,
  parameter int DW        = 8,
  parameter int BANK_BITS = 2,
  parameter int REG_BITS  = 3
) (
  input  logic [BANK_BITS-1:0] bank,
  input  logic [REG_BITS-1:0]  rsel,
  input  logic [DW-1:0]        acc,
  input  logic [CODE_AW-1:0]   dptr,
  input  logic [CODE_AW-1:0]   pc,
  input  logic                 use_pc,
  output logic [DATA_AW-1:0]   reg_addr,
  output logic [DATA_AW-1:0]   ptr_addr,
  output logic [CODE_AW-1:0]   tbl_addr
);

  localparam int BR_W = BANK_BITS + REG_BITS;

  logic [CODE_AW-1:0] base;
  logic [BR_W-1:0]    reg_idx;
  logic [BR_W-1:0]    ptr_idx;

  assign reg_idx = {bank, rsel};
  assign ptr_idx = {bank, {(REG_BITS-1){1'b0}}, rsel[0]};

  generate
    if (DATA_AW > BR_W) begin : g_pad
      assign reg_addr = {{(DATA_AW-BR_W){1'b0}}, reg_idx};
      assign ptr_addr = {{(DATA_AW-BR_W){1'b0}}, ptr_idx};
    end else begin : g_exact
      assign reg_addr = reg_idx[DATA_AW-1:0];
      assign ptr_addr = ptr_idx[DATA_AW-1:0];
    end
  endgenerate

  // table base is either the data pointer or the address after the opcode
  assign base     = use_pc ? pc + CODE_AW'(1) : dptr;
  assign tbl_addr = base + {{(CODE_AW-DW){1'b0}}, acc};

endmodule

// File: rtl/acc_load_core.sv
module acc_load_core
  import acc_load_pkg::*;
#(
  parameter int             CODE_AW   = 16,
  parameter int             DATA_AW   = 8,
  parameter int             DW        = 8,
  parameter int             BANK_BITS = 2,
  parameter int             REG_BITS  = 3,
  parameter int             BANK_LSB  = 3,
  parameter logic [DW-1:0]  ACC_ALIAS = 8'hE0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               cfg_we,
  input  logic [CODE_AW-1:0] cfg_pc,
  input  logic [CODE_AW-1:0] cfg_dptr,
  input  logic [DW-1:0]      cfg_status,
  output logic               code_rd,
  output logic [CODE_AW-1:0] code_addr,
  input  logic [DW-1:0]      code_data,
  output logic               data_rd,
  output logic [DATA_AW-1:0] data_addr,
  input  logic [DW-1:0]      data_rdata,
  output logic [DW-1:0]      acc,
  output logic [CODE_AW-1:0] pc,
  output logic [DW-1:0]      status,
  output logic               done,
  output logic [1:0]         mcycles
);

  localparam logic [CODE_AW-1:0] ONE = CODE_AW'(1);
  localparam logic [CODE_AW-1:0] TWO = CODE_AW'(2);

  core_state_t        state;
  op_kind_t           kind;
  op_kind_t           dec_kind;
  logic [CODE_AW-1:0] dptr;
  logic [DATA_AW-1:0] reg_addr;
  logic [DATA_AW-1:0] ptr_addr;
  logic [CODE_AW-1:0] tbl_addr;
  logic               alias_hit;

  acc_load_decode #(.DW(DW)) u_dec (
    .opcode (code_data),
    .kind   (dec_kind)
  );

  acc_load_agen #(
    .CODE_AW  (CODE_AW),
    .DATA_AW  (DATA_AW),
    .DW       (DW),
    .BANK_BITS(BANK_BITS),
    .REG_BITS (REG_BITS)
  ) u_agen (
    .bank    (status[BANK_LSB +: BANK_BITS]),
    .rsel    (code_data[REG_BITS-1:0]),
    .acc     (acc),
    .dptr    (dptr),
    .pc      (pc),
    .use_pc  (dec_kind == K_TPC),
    .reg_addr(reg_addr),
    .ptr_addr(ptr_addr),
    .tbl_addr(tbl_addr)
  );

  assign alias_hit = (code_data == ACC_ALIAS);

  // memory request formation
  always_comb begin
    code_rd   = 1'b0;
    code_addr = pc;
    data_rd   = 1'b0;
    data_addr = reg_addr;
    case (state)
      S_FETCH: code_rd = run;
      S_DEC: begin
        case (dec_kind)
          K_IMM, K_DIR: begin
            code_rd   = 1'b1;
            code_addr = pc + ONE;
          end
          K_REG: data_rd = 1'b1;
          K_IND: begin
            data_rd   = 1'b1;
            data_addr = ptr_addr;
          end
          K_TDP, K_TPC: begin
            code_rd   = 1'b1;
            code_addr = tbl_addr;
          end
          default: ;
        endcase
      end
      S_OPND: begin
        if (kind == K_DIR && !alias_hit) begin
          data_rd   = 1'b1;
          data_addr = DATA_AW'(code_data);
        end
      end
      S_PTR: begin
        data_rd   = 1'b1;
        data_addr = DATA_AW'(data_rdata);
      end
      default: ;
    endcase
  end

  // sequencing and architectural state
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_FETCH;
      kind    <= K_NOP;
      acc     <= '0;
      pc      <= '0;
      dptr    <= '0;
      status  <= '0;
      done    <= 1'b0;
      mcycles <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_FETCH: begin
          if (run) begin
            state <= S_DEC;
          end else if (cfg_we) begin
            pc     <= cfg_pc;
            dptr   <= cfg_dptr;
            status <= cfg_status;
          end
        end
        S_DEC: begin
          kind <= dec_kind;
          case (dec_kind)
            K_IMM, K_DIR: state <= S_OPND;
            K_REG:        state <= S_DATA;
            K_IND:        state <= S_PTR;
            K_TDP, K_TPC: state <= S_CODE;
            default: begin
              pc      <= pc + ONE;
              done    <= 1'b1;
              mcycles <= 2'd1;
              state   <= S_FETCH;
            end
          endcase
        end
        S_OPND: begin
          if (kind == K_IMM || alias_hit) begin
            if (kind == K_IMM) acc <= code_data;
            pc      <= pc + TWO;
            done    <= 1'b1;
            mcycles <= 2'd1;
            state   <= S_FETCH;
          end else begin
            state <= S_DATA;
          end
        end
        S_PTR: state <= S_DATA;
        S_DATA: begin
          acc     <= data_rdata;
          pc      <= pc + ((kind == K_DIR) ? TWO : ONE);
          done    <= 1'b1;
          mcycles <= 2'd1;
          state   <= S_FETCH;
        end
        S_CODE: begin
          acc     <= code_data;
          pc      <= pc + ONE;
          done    <= 1'b1;
          mcycles <= 2'd2;
          state   <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  pc_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (pc != $past(pc) && !$past(state == S_FETCH && cfg_we && !run)) |-> done);

  // R11
  acc_moves_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (acc != $past(acc)) |-> done);

  // R8
  two_cycle_only_table_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mcycles == 2'd2) |-> $past(state == S_CODE));

  // R7
  pointer_reg_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_DEC && dec_kind == K_IND) |-> (data_rd && data_addr[REG_BITS-1:1] == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH && !run) |-> (!code_rd && !data_rd));

endmodule

// File: tb/acc_load_core_tb.sv
module acc_load_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_pc = '0;
  logic [15:0] cfg_dptr = '0;
  logic [7:0]  cfg_status = '0;
  logic        code_rd;
  logic [15:0] code_addr;
  logic [7:0]  code_data = '0;
  logic        data_rd;
  logic [7:0]  data_addr;
  logic [7:0]  data_rdata = '0;
  logic [7:0]  acc;
  logic [15:0] pc;
  logic [7:0]  status;
  logic        done;
  logic [1:0]  mcycles;

  logic [7:0]  cmem [0:65535];
  logic [7:0]  dmem [0:255];

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_pc = '0;
  logic [7:0]  exp_acc = '0;

  always #10 clk = ~clk;

  acc_load_core u_dut (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_pc(cfg_pc),
    .cfg_dptr(cfg_dptr), .cfg_status(cfg_status), .code_rd(code_rd),
    .code_addr(code_addr), .code_data(code_data), .data_rd(data_rd),
    .data_addr(data_addr), .data_rdata(data_rdata), .acc(acc), .pc(pc),
    .status(status), .done(done), .mcycles(mcycles)
  );

  always @(posedge clk) begin
    if (code_rd) code_data <= cmem[code_addr];
    if (data_rd) data_rdata <= dmem[data_addr];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] op, input logic [7:0] b1);
    logic [15:0] nxt;
    nxt = exp_pc + 16'd1;
    cmem[exp_pc] = op;
    cmem[nxt] = b1;
  endtask

  task automatic setup(input logic [15:0] npc, input logic [15:0] ndp, input logic [7:0] nst);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pc = npc; cfg_dptr = ndp; cfg_status = nst;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_pc = npc;
    check("R6 status load", {24'd0, status}, {24'd0, nst});
  endtask

  task automatic exec(input string req, input int eclk, input logic [15:0] len,
                      input logic [7:0] eacc, input logic [1:0] emc);
    int n;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    n = 1;
    while (done !== 1'b1 && n < 16) begin
      @(negedge clk);
      n++;
    end
    check({req, " clocks"}, n, eclk);
    check({req, " acc"}, {24'd0, acc}, {24'd0, eacc});
    check({req, " pc"}, {16'd0, pc}, {16'd0, exp_pc + len});
    check({req, " mcycles"}, {30'd0, mcycles}, {30'd0, emc});
    @(negedge clk);
    check("R11 done width", {31'd0, done}, 32'd0);
    exp_pc = exp_pc + len;
    exp_acc = eacc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] a16;
    for (int i = 0; i < 65536; i++) begin
      a16 = 16'(i);
      cmem[i] = a16[7:0] ^ a16[15:8] ^ 8'h5A;
    end
    for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'hC3 ^ 8'(i * 7);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 acc", {24'd0, acc}, 0);
    check("R1 pc", {16'd0, pc}, 0);
    check("R1 status", {24'd0, status}, 0);
    check("R1 done", {31'd0, done}, 0);
    check("R1 idle reads", {30'd0, code_rd, data_rd}, 0);

    // R2 immediate sweep
    for (int k = 0; k < 256; k += 15) begin
      v = 8'(k) ^ 8'hA5;
      put(8'h74, v);
      exec("R2 imm", 3, 16'd2, v, 2'd1);
    end
    setup(16'hFFFF, 16'h0000, 8'h00);
    put(8'h74, 8'h3C);
    exec("R2 imm wrap", 3, 16'd2, 8'h3C, 2'd1);

    // R3 and R4 direct sweep over all addresses
    setup(16'h0400, 16'h0000, 8'h00);
    for (int a = 0; a < 256; a++) begin
      put(8'hE5, 8'(a));
      if (a == 8'hE0) exec("R4 alias", 3, 16'd2, exp_acc, 2'd1);
      else exec("R3 direct", 4, 16'd2, dmem[a], 2'd1);
    end
    put(8'h74, 8'h96);
    exec("R2 imm", 3, 16'd2, 8'h96, 2'd1);
    put(8'hE5, 8'hE0);
    exec("R4 alias keeps acc", 3, 16'd2, 8'h96, 2'd1);

    // R5 and R6 register sweep in every bank, other status bits noisy
    for (int b = 0; b < 4; b++) begin
      setup(16'h1000 + 16'(b * 64), 16'h0000, 8'hE7 | 8'(b << 3));
      for (int r = 0; r < 8; r++) begin
        put(8'hE8 + 8'(r), 8'h00);
        exec("R5 R6 register", 3, 16'd1, dmem[b*8 + r], 2'd1);
      end
    end

    // R7 indirect through R0 and R1 in every bank
    for (int b = 0; b < 4; b++) begin
      setup(16'h2000 + 16'(b * 64), 16'h0000, 8'(b << 3));
      for (int i = 0; i < 2; i++) begin
        v = (b == 3 && i == 1) ? 8'hE0 : 8'h40 + 8'(b * 16 + i * 5);
        dmem[b*8 + i] = v;
        dmem[b*8 + 2] = 8'h11;
        put(8'hE6 + 8'(i), 8'h00);
        exec("R7 indirect", 4, 16'd1, dmem[v], 2'd1);
      end
    end

    // R8 data-pointer table reads
    begin
      logic [15:0] dps [0:3];
      logic [7:0]  avs [0:3];
      dps[0] = 16'h01FE; avs[0] = 8'h02;
      dps[1] = 16'hFFFF; avs[1] = 8'h02;
      dps[2] = 16'h1234; avs[2] = 8'h00;
      dps[3] = 16'h00FF; avs[3] = 8'hFF;
      for (int t = 0; t < 4; t++) begin
        setup(16'h3000 + 16'(t * 16), dps[t], 8'h00);
        put(8'h74, avs[t]);
        exec("R2 imm", 3, 16'd2, avs[t], 2'd1);
        put(8'h93, 8'h00);
        a16 = dps[t] + {8'h00, avs[t]};
        exec("R8 dptr table", 3, 16'd1, cmem[a16], 2'd2);
      end
    end

    // R9 pc-relative table reads, one wrapping past FFFFh
    setup(16'hFFFB, 16'h0000, 8'h00);
    put(8'h74, 8'h05);
    exec("R2 imm", 3, 16'd2, 8'h05, 2'd1);
    put(8'h83, 8'h00);
    a16 = exp_pc + 16'd1 + 16'h0005;
    exec("R9 pc table wrap", 3, 16'd1, cmem[a16], 2'd2);
    setup(16'h5000, 16'h0000, 8'h00);
    put(8'h74, 8'h10);
    exec("R2 imm", 3, 16'd2, 8'h10, 2'd1);
    put(8'h83, 8'h00);
    a16 = exp_pc + 16'd1 + 16'h0010;
    exec("R9 pc table", 3, 16'd1, cmem[a16], 2'd2);

    // R10 every other opcode is a no-op
    setup(16'h6000, 16'h0000, 8'h00);
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h74 || op == 8'hE5 || op == 8'hE6 || op == 8'hE7 ||
          op == 8'h93 || op == 8'h83 || (op >= 8'hE8 && op <= 8'hEF)) continue;
      put(8'(op), 8'h74);
      exec("R10 no-op", 2, 16'd1, exp_acc, 2'd1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule